// File: doc/BRIEF.md
# Shared Memory Ownership Arbiter

This block decides which of two requesters may reach a shared memory. One is a contactless tag command front end. The other is a host on a secondary serial port. By default the tag side owns the memory. If both sides ask in the same cycle, the tag side wins and the serial request is held back. The arbiter also watches the tag write commands after they are decoded. It looks for a handover pattern: a write to user word 0x004, followed by a write to user word 0x005 whose data XORed with the first word gives 0x1234.

When that pattern is seen, the block raises an interrupt toward the host by driving the serial chip-select line high. The host answers by pulsing the serial clock twice. Ownership then moves to the host, which keeps the memory to itself. Every tag command is turned away during this time. The host gives the memory back by sending a complete release instruction. A reset also gives the memory back.

The serial clock and chip-select pins are sampled into the system clock domain through synchronizer flops. The decoded frame strobe, the opcode and the full-word flag are already in the system clock domain.

Top module: `mem_own_arbiter`

## Requirements
- R1: After reset, `own_state` is 3'b001 (tag owns) and `irq_cs_drive` is 0.
- R2: While the tag side owns the memory, the grants follow the requests as follows:
  - With `tag_req` and `spi_req` both high in the same cycle, `tag_grant`=1, `spi_grant`=0 and `spi_stall`=1.
  - With `spi_req` alone, `spi_grant`=1.
  - With `tag_req` alone, `tag_grant`=1.
- R3: A counted write to word 0x004 followed by a counted write to word 0x005 whose two data words XOR to 0x1234 moves the block to the interrupt state. The move is visible from the clock edge that takes the 0x005 write: `own_state`=3'b010 and `irq_cs_drive`=1. Any pair of words with that XOR qualifies.
- R4: A 0x004/0x005 pair whose data XOR is not 0x1234 leaves `own_state` at 3'b001.
- R5: A tag write counts toward the trigger only when `tag_state` is 2'b10 (OPEN) or 2'b11 (SECURED). Writes made with `tag_state` 2'b00 or 2'b01 never fire the trigger.
- R6: Only a 0x005 write that comes after a captured 0x004 word fires the trigger. The captured 0x004 word stays held until the trigger fires, and it is cleared when the trigger fires.
- R7: In the interrupt state, with chip-select high, the second rising edge of the serial clock moves the block to host ownership (`own_state`=3'b100) and drops `irq_cs_drive`. After only one edge the block stays in the interrupt state.
- R8: While the host owns the memory, the following hold:
  - `tag_grant` stays 0.
  - A tag request or write gives a `tag_ignored` pulse in the same cycle.
  - `spi_grant` follows `spi_req`, and `spi_stall` stays 0.
  - A trigger pattern written by the tag side has no effect.
- R9: Host ownership ends, and the block returns to 3'b001, only on a frame strobe carrying opcode 4'b1110 with `spi_frame_full`=1. Another opcode, or that opcode without a full data word, keeps host ownership.
- R10: A reset taken during host ownership returns `own_state` to 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tag_req | input | 1 | Tag side memory request |
| tag_wr_vld | input | 1 | Decoded tag write strobe, one cycle |
| tag_addr | input | 9 | Tag write user word address |
| tag_data | input | 16 | Tag write data word |
| tag_state | input | 2 | Tag security state (2'b10 OPEN, 2'b11 SECURED) |
| spi_req | input | 1 | Serial port memory request |
| spi_clk_in | input | 1 | Serial clock pin, asynchronous |
| spi_cs_in | input | 1 | Serial chip-select pin level, asynchronous |
| spi_frame_vld | input | 1 | Decoded serial instruction complete strobe |
| spi_frame_full | input | 1 | A full data word followed the instruction word |
| spi_opcode | input | 4 | Decoded serial instruction opcode |
| tag_grant | output | 1 | Tag request granted this cycle |
| spi_grant | output | 1 | Serial request granted this cycle |
| spi_stall | output | 1 | Serial request held back this cycle |
| tag_ignored | output | 1 | Tag command turned away this cycle |
| irq_cs_drive | output | 1 | Drive chip-select high toward the host (interrupt) |
| own_state | output | 3 | One-hot ownership: bit0 tag, bit1 interrupt, bit2 host |

## Verification
The main risk is a wrong ownership state, because every grant reads that state in the same cycle. A wrong state shows at once as a tag grant during host ownership, or as a missing stall. A stale or uncleared capture register is harder to see. It only shows on a later 0x005 write, as an unexpected interrupt, so the bench sends a lone 0x005 write after a full handover and release. Acknowledge counting passes through the synchronizer, so any fault in the edge count shows about three cycles after a serial clock edge, as an early or late change of `own_state`.

// File: rtl/mem_own_pkg.sv
package mem_own_pkg;
    typedef enum logic [1:0] {
        OWN_TAG  = 2'd0,
        OWN_IRQ  = 2'd1,
        OWN_HOST = 2'd2
    } own_e;

    localparam logic [1:0] TST_OPEN    = 2'b10;
    localparam logic [1:0] TST_SECURED = 2'b11;
endpackage

// File: rtl/mo_sync.sv
module mo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    // Index STAGES is the previous synchronized level, used for edge detection.
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/mo_trigger.sv
module mo_trigger #(
    parameter int              ADDR_W = 9,
    parameter int              DATA_W = 16,
    parameter logic [ADDR_W-1:0] FIRST_ADDR = 9'h004,
    parameter logic [ADDR_W-1:0] SECOND_ADDR = 9'h005,
    parameter logic [DATA_W-1:0] MAGIC = 16'h1234
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              fire
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] word;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        fire  = wr_en && (addr == SECOND_ADDR) && cap_q.vld
                && ((cap_q.word ^ data) == MAGIC);
        cap_d = cap_q;
        if (fire) begin
            cap_d = '0;
        end else if (wr_en && (addr == FIRST_ADDR)) begin
            cap_d.vld  = 1'b1;
            cap_d.word = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end
endmodule

// File: rtl/mo_port_mux.sv
module mo_port_mux
    import mem_own_pkg::*;
(
    input  own_e st,
    input  logic tag_req,
    input  logic tag_cmd,
    input  logic spi_req,
    output logic tag_grant,
    output logic spi_grant,
    output logic spi_stall,
    output logic tag_ignored
);
    always_comb begin
        tag_grant   = 1'b0;
        spi_grant   = 1'b0;
        spi_stall   = 1'b0;
        tag_ignored = 1'b0;
        if (st == OWN_TAG) begin
            tag_grant = tag_req;
            spi_grant = spi_req & ~tag_req;
            spi_stall = spi_req & tag_req;
        end else begin
            spi_grant   = spi_req;
            tag_ignored = tag_cmd;
        end
    end
endmodule

// File: rtl/mem_own_arbiter.sv
module mem_own_arbiter
    import mem_own_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 16,
    parameter int OP_W        = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ACK_EDGES   = 2,
    parameter logic [ADDR_W-1:0] FIRST_ADDR  = 9'h004,
    parameter logic [ADDR_W-1:0] SECOND_ADDR = 9'h005,
    parameter logic [DATA_W-1:0] MAGIC       = 16'h1234,
    parameter logic [OP_W-1:0]   RELEASE_OP  = 4'b1110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tag_req,
    input  logic              tag_wr_vld,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [DATA_W-1:0] tag_data,
    input  logic [1:0]        tag_state,
    input  logic              spi_req,
    input  logic              spi_clk_in,
    input  logic              spi_cs_in,
    input  logic              spi_frame_vld,
    input  logic              spi_frame_full,
    input  logic [OP_W-1:0]   spi_opcode,
    output logic              tag_grant,
    output logic              spi_grant,
    output logic              spi_stall,
    output logic              tag_ignored,
    output logic              irq_cs_drive,
    output logic [2:0]        own_state
);
    localparam int CNT_W = $clog2(ACK_EDGES + 1);
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(ACK_EDGES - 1);

    typedef struct packed {
        own_e             st;
        logic [CNT_W-1:0] edges;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    // Serial pins into the system domain: index 0 clock, index 1 chip-select.
    logic [1:0] pin_raw, pin_lvl, pin_rise;
    assign pin_raw = {spi_cs_in, spi_clk_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        mo_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_raw[g]),
            .level (pin_lvl[g]),
            .rise  (pin_rise[g])
        );
    end

    logic trig_en, trig_fire, state_ok, release_ok;

    assign state_ok = (tag_state == TST_OPEN) || (tag_state == TST_SECURED);
    assign trig_en  = tag_wr_vld && state_ok && (fsm_q.st == OWN_TAG);

    mo_trigger #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .FIRST_ADDR  (FIRST_ADDR),
        .SECOND_ADDR (SECOND_ADDR),
        .MAGIC       (MAGIC)
    ) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (trig_en),
        .addr  (tag_addr),
        .data  (tag_data),
        .fire  (trig_fire)
    );

    assign release_ok = spi_frame_vld && spi_frame_full && (spi_opcode == RELEASE_OP);

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            OWN_TAG: begin
                if (trig_fire) begin
                    fsm_d.st    = OWN_IRQ;
                    fsm_d.edges = '0;
                end
            end
            OWN_IRQ: begin
                if (pin_lvl[1] && pin_rise[0]) begin
                    if (fsm_q.edges == LAST_EDGE) begin
                        fsm_d.st    = OWN_HOST;
                        fsm_d.edges = '0;
                    end else begin
                        fsm_d.edges = fsm_q.edges + 1'b1;
                    end
                end
            end
            OWN_HOST: begin
                if (release_ok) fsm_d.st = OWN_TAG;
            end
            default: fsm_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '0;
        else        fsm_q <= fsm_d;
    end

    mo_port_mux u_mux (
        .st          (fsm_q.st),
        .tag_req     (tag_req),
        .tag_cmd     (tag_req | tag_wr_vld),
        .spi_req     (spi_req),
        .tag_grant   (tag_grant),
        .spi_grant   (spi_grant),
        .spi_stall   (spi_stall),
        .tag_ignored (tag_ignored)
    );

    assign irq_cs_drive = (fsm_q.st == OWN_IRQ);
    assign own_state    = {fsm_q.st == OWN_HOST, fsm_q.st == OWN_IRQ, fsm_q.st == OWN_TAG};
endmodule

// File: rtl/mem_own_checker.sv
module mem_own_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tag_req,
    input logic       spi_req,
    input logic       tag_grant,
    input logic       spi_grant,
    input logic       spi_stall,
    input logic       irq_cs_drive,
    input logic       spi_frame_vld,
    input logic       spi_frame_full,
    input logic [2:0] own_state
);
    p_state_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(own_state) == 1);

    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tag_grant && spi_grant));

    p_tag_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (own_state[0] && tag_req && spi_req) |-> (tag_grant && spi_stall));

    p_irq_from_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_cs_drive) |-> $past(own_state[0]));

    p_host_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_state[2]) |-> ($past(own_state[1]) && !irq_cs_drive));

    p_host_blocks_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        own_state[2] |-> (!tag_grant && (spi_grant == spi_req)));

    p_release_needs_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_state[2]) |-> (own_state[0] && $past(spi_frame_vld && spi_frame_full)));
endmodule

bind mem_own_arbiter mem_own_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tag_req        (tag_req),
    .spi_req        (spi_req),
    .tag_grant      (tag_grant),
    .spi_grant      (spi_grant),
    .spi_stall      (spi_stall),
    .irq_cs_drive   (irq_cs_drive),
    .spi_frame_vld  (spi_frame_vld),
    .spi_frame_full (spi_frame_full),
    .own_state      (own_state)
);

// File: tb/tb_mem_own_arbiter.sv
`timescale 1ns/1ps
module tb_mem_own_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tag_req, tag_wr_vld, spi_req, spi_clk_in, host_cs;
    logic        spi_frame_vld, spi_frame_full;
    logic [8:0]  tag_addr;
    logic [15:0] tag_data;
    logic [1:0]  tag_state;
    logic [3:0]  spi_opcode;
    logic        tag_grant, spi_grant, spi_stall, tag_ignored, irq_cs_drive;
    logic        spi_cs_in;
    logic [2:0]  own_state;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // Chip-select pad: the device drives it high, the host may also pull it high.
    assign spi_cs_in = irq_cs_drive | host_cs;

    mem_own_arbiter dut (
        .clk(clk), .rst_n(rst_n), .tag_req(tag_req), .tag_wr_vld(tag_wr_vld),
        .tag_addr(tag_addr), .tag_data(tag_data), .tag_state(tag_state),
        .spi_req(spi_req), .spi_clk_in(spi_clk_in), .spi_cs_in(spi_cs_in),
        .spi_frame_vld(spi_frame_vld), .spi_frame_full(spi_frame_full),
        .spi_opcode(spi_opcode), .tag_grant(tag_grant), .spi_grant(spi_grant),
        .spi_stall(spi_stall), .tag_ignored(tag_ignored),
        .irq_cs_drive(irq_cs_drive), .own_state(own_state)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tag_req = 0; tag_wr_vld = 0; spi_req = 0; spi_clk_in = 0; host_cs = 0;
        spi_frame_vld = 0; spi_frame_full = 0; tag_addr = '0; tag_data = '0;
        tag_state = 2'b10; spi_opcode = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tag_write(input logic [1:0] st, input logic [8:0] a, input logic [15:0] d);
        tag_state = st; tag_addr = a; tag_data = d; tag_wr_vld = 1'b1;
        @(negedge clk);
        tag_wr_vld = 1'b0;
    endtask

    task automatic sclk_pulse();
        spi_clk_in = 1'b1;
        repeat (4) @(negedge clk);
        spi_clk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(input logic [3:0] op, input logic full);
        spi_opcode = op; spi_frame_full = full; spi_frame_vld = 1'b1;
        @(negedge clk);
        spi_frame_vld = 1'b0; spi_frame_full = 1'b0;
    endtask

    task automatic to_host();
        tag_write(2'b10, 9'h004, 16'h1200);
        tag_write(2'b10, 9'h005, 16'h0034);
        repeat (4) @(negedge clk);
        sclk_pulse();
        sclk_pulse();
    endtask

    // {fire, tag_state, word@0x004, word@0x005}
    localparam logic [34:0] VEC [8] = '{
        {1'b1, 2'b10, 16'h1200, 16'h0034},
        {1'b1, 2'b11, 16'hFFFF, 16'hEDCB},
        {1'b1, 2'b10, 16'h0000, 16'h1234},
        {1'b1, 2'b10, 16'hABCD, 16'hB9F9},
        {1'b0, 2'b10, 16'h1200, 16'h0035},
        {1'b0, 2'b11, 16'h1234, 16'h1234},
        {1'b0, 2'b00, 16'h1200, 16'h0034},
        {1'b0, 2'b01, 16'h1200, 16'h0034}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 own_state", 16'(own_state), 16'h1);
        chk("R1 irq_cs_drive", 16'(irq_cs_drive), 16'h0);

        // Trigger vector table: R3, R4, R5
        for (int i = 0; i < 8; i++) begin
            do_reset();
            tag_write(VEC[i][33:32], 9'h004, VEC[i][31:16]);
            tag_write(VEC[i][33:32], 9'h005, VEC[i][15:0]);
            if (VEC[i][34]) begin
                chk($sformatf("R3 vec%0d own_state", i), 16'(own_state), 16'h2);
                chk($sformatf("R3 vec%0d cs_drive", i), 16'(irq_cs_drive), 16'h1);
            end else if (VEC[i][33:32] inside {2'b00, 2'b01}) begin
                chk($sformatf("R5 vec%0d own_state", i), 16'(own_state), 16'h1);
            end else begin
                chk($sformatf("R4 vec%0d own_state", i), 16'(own_state), 16'h1);
            end
        end

        // R2 arbitration while tag owns
        do_reset();
        tag_req = 1; spi_req = 1; #1;
        chk("R2 both tag_grant", 16'(tag_grant), 16'h1);
        chk("R2 both spi_grant", 16'(spi_grant), 16'h0);
        chk("R2 both spi_stall", 16'(spi_stall), 16'h1);
        tag_req = 0; #1;
        chk("R2 spi alone grant", 16'(spi_grant), 16'h1);
        chk("R2 spi alone stall", 16'(spi_stall), 16'h0);
        tag_req = 1; spi_req = 0; #1;
        chk("R2 tag alone grant", 16'(tag_grant), 16'h1);
        tag_req = 0;
        @(negedge clk);

        // R6 order and capture persistence
        do_reset();
        tag_write(2'b10, 9'h005, 16'h0034);
        chk("R6 lone 0x005", 16'(own_state), 16'h1);
        tag_write(2'b10, 9'h004, 16'h1200);
        tag_write(2'b10, 9'h005, 16'h0000);
        chk("R6 mismatch keeps tag", 16'(own_state), 16'h1);
        tag_write(2'b10, 9'h005, 16'h0034);
        chk("R6 held capture fires", 16'(own_state), 16'h2);

        // R7 acknowledge
        repeat (4) @(negedge clk);
        sclk_pulse();
        chk("R7 one edge pending", 16'(own_state), 16'h2);
        chk("R7 one edge cs", 16'(irq_cs_drive), 16'h1);
        sclk_pulse();
        chk("R7 two edges host", 16'(own_state), 16'h4);
        chk("R7 cs released", 16'(irq_cs_drive), 16'h0);

        // R8 host ownership
        tag_req = 1; spi_req = 1; #1;
        chk("R8 tag_grant", 16'(tag_grant), 16'h0);
        chk("R8 tag_ignored", 16'(tag_ignored), 16'h1);
        chk("R8 spi_grant", 16'(spi_grant), 16'h1);
        chk("R8 spi_stall", 16'(spi_stall), 16'h0);
        tag_req = 0; spi_req = 0;
        @(negedge clk);
        tag_write(2'b10, 9'h004, 16'h1200);
        tag_write(2'b10, 9'h005, 16'h0034);
        chk("R8 trigger ignored", 16'(own_state), 16'h4);

        // R9 release
        send_frame(4'b0110, 1'b1);
        chk("R9 other opcode", 16'(own_state), 16'h4);
        send_frame(4'b1110, 1'b0);
        chk("R9 no data word", 16'(own_state), 16'h4);
        send_frame(4'b1110, 1'b1);
        chk("R9 release", 16'(own_state), 16'h1);
        // R6 capture was cleared on fire
        tag_write(2'b10, 9'h005, 16'h0034);
        chk("R6 capture cleared", 16'(own_state), 16'h1);

        // R10 reset out of host ownership
        do_reset();
        to_host();
        chk("R10 reached host", 16'(own_state), 16'h4);
        do_reset();
        chk("R10 reset to tag", 16'(own_state), 16'h1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end
endmodule